// File: doc/BRIEF.md
# PC Card configuration and decode unit

This block holds the card-side configuration state of a removable storage card that sits on a PC Card style host bus. The host reaches two byte-wide registers through attribute-memory strobes. The option register at byte address 200h picks the addressing mode, chooses the interrupt form and holds the card in soft reset. The card status register at byte address 202h carries a few host-writable flags and reports the pending interrupt.

From the option register the unit works out one of four addressing modes. It turns host I/O cycles into a hit flag and a 4-bit register slot for the task-file logic of the card core. It also shapes the core's interrupt request into an active-low host interrupt, either as a level or as a fixed-width pulse. All host inputs are plain single-cycle strobes sampled on the clock. There is no data stream, so the block has no valid/ready handshake and applies no back-pressure: an access is complete in the cycle its strobe is high.

Top module: `pcc_cfg_unit`

## Requirements
- R1: After hardware reset (rst_n low), a read of the option register (200h) and a read of the status register (202h) both return 00h, host_irq_n is 1, core_rst is 0 and cfg_mode is 0.
- R2: While the soft-reset bit is 0, a write to 200h stores all eight bits. Bit 7 is soft reset, bit 6 selects level interrupt, bits 5..0 are the configuration index. A read of 200h returns the stored byte.
- R3: core_rst equals the stored bit 7 of 200h. The card clears this bit only on hardware reset. A write with bit 7 set clears bits 6..0 of 200h and the stored status-register bits. While bit 7 is set, a write to 200h changes only bit 7, so writing 00h leaves every field at 0.
- R4: A write to 202h stores only bit 6, bit 5 and bit 2, and only while soft reset is 0. A read of 202h returns those bits, returns bit 1 as the registered interrupt request in either interrupt mode, and returns 0 in bits 7, 4, 3 and 0.
- R5: cfg_mode is 1 for index 1, 2 for index 2, 3 for index 3, and 0 for index 0 or any other index value.
- R6: In mode 1, every I/O read or write strobe gives io_hit=1 with io_slot equal to address bits 3..0. io_hit is 0 whenever neither I/O strobe is high.
- R7: In mode 2, I/O addresses 1F0h-1F7h hit slots 0-7 and 3F6h/3F7h hit slots 14/15, by full address compare. Every other address misses.
- R8: In mode 3, I/O addresses 170h-177h hit slots 0-7 and 376h/377h hit slots 14/15, by full address compare. Every other address misses.
- R9: In mode 0, and while soft reset is set, io_hit stays 0 for every I/O strobe.
- R10: With bit 6 of 200h set, host_irq_n is the inverse of irq_req, delayed by one clock.
- R11: With bit 6 of 200h clear, each rising edge of irq_req drives host_irq_n low for exactly 4 clocks, starting one clock after the edge. A steady level of irq_req does not extend the pulse.
- R12: host_rdata is 00h when attr_re is low, and it is 00h for any attribute address other than 200h and 202h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| host_addr | input | 11 | Host address for attribute and I/O cycles |
| host_wdata | input | 8 | Host write data |
| attr_we | input | 1 | Attribute-memory write strobe |
| attr_re | input | 1 | Attribute-memory read strobe |
| host_rdata | output | 8 | Attribute read data, combinational |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_hit | output | 1 | The current I/O cycle selects a card register |
| io_slot | output | 4 | Task-file register slot of the hit |
| cfg_mode | output | 2 | Active addressing mode (0 memory, 1 any 16-byte, 2 primary, 3 secondary) |
| core_rst | output | 1 | Soft reset to the card core |
| irq_req | input | 1 | Interrupt request from the card core |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
Assertions check several rules on every cycle. A hit never occurs without an I/O strobe, in memory mode or during soft reset. Releasing soft reset always leaves the index and the interrupt select at zero. Reserved status bits always read zero. The level interrupt always tracks the request one clock later, and a pulse in progress is never cut short. Other behaviour is only visible in the bench scenarios: the exact slot chosen for each fixed-window address, the exact four-clock pulse width, and the masking of writes during soft reset.

// File: rtl/pcc_cfg_pkg.sv
`timescale 1ns/1ps
package pcc_cfg_pkg;
  typedef enum logic [1:0] {
    MODE_MEM   = 2'd0,
    MODE_ANY16 = 2'd1,
    MODE_PRI   = 2'd2,
    MODE_SEC   = 2'd3
  } addr_mode_e;

  function automatic addr_mode_e idx_to_mode(input logic [5:0] idx);
    case (idx)
      6'd1:    return MODE_ANY16;
      6'd2:    return MODE_PRI;
      6'd3:    return MODE_SEC;
      default: return MODE_MEM;
    endcase
  endfunction
endpackage

// File: rtl/pcc_cfg_regs.sv
`timescale 1ns/1ps
module pcc_cfg_regs #(
  parameter int ADDR_W   = 11,
  parameter int OPT_ADDR = 'h200,
  parameter int STS_ADDR = 'h202
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              attr_we,
  input  logic              attr_re,
  input  logic              int_stat,
  output logic [7:0]        rdata,
  output logic              soft_rst,
  output logic              lvl_irq,
  output logic [5:0]        cfg_index
);
  localparam logic [ADDR_W-1:0] OPT_A = ADDR_W'(OPT_ADDR);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);

  logic       soft_rst_q, lvl_q;
  logic [5:0] idx_q;
  logic       sig_en_q, bus8_q, pwr_dn_q;
  logic       opt_wr, sts_wr;

  assign opt_wr = attr_we && (addr == OPT_A);
  assign sts_wr = attr_we && (addr == STS_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_q <= 1'b0;
      lvl_q      <= 1'b0;
      idx_q      <= '0;
    end else if (opt_wr) begin
      soft_rst_q <= wdata[7];
      if (wdata[7] || soft_rst_q) begin
        lvl_q <= 1'b0;
        idx_q <= '0;
      end else begin
        lvl_q <= wdata[6];
        idx_q <= wdata[5:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_en_q <= 1'b0;
      bus8_q   <= 1'b0;
      pwr_dn_q <= 1'b0;
    end else if (soft_rst_q || (opt_wr && wdata[7])) begin
      sig_en_q <= 1'b0;
      bus8_q   <= 1'b0;
      pwr_dn_q <= 1'b0;
    end else if (sts_wr) begin
      sig_en_q <= wdata[6];
      bus8_q   <= wdata[5];
      pwr_dn_q <= wdata[2];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (attr_re) begin
      if (addr == OPT_A)      rdata = {soft_rst_q, lvl_q, idx_q};
      else if (addr == STS_A) rdata = {1'b0, sig_en_q, bus8_q, 2'b00, pwr_dn_q, int_stat, 1'b0};
    end
  end

  assign soft_rst  = soft_rst_q;
  assign lvl_irq   = lvl_q;
  assign cfg_index = idx_q;

  AST_SRST_LEAVES_UNCONF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_q) |-> (idx_q == 6'd0 && !lvl_q)) else $error("AST_SRST_LEAVES_UNCONF"); // R3
  AST_SRST_FREEZES_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_q && $past(soft_rst_q)) |-> !(sig_en_q || bus8_q || pwr_dn_q)) else $error("AST_SRST_FREEZES_STS"); // R3
endmodule

// File: rtl/pcc_io_decode.sv
`timescale 1ns/1ps
module pcc_io_decode
  import pcc_cfg_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PRI_TF  = 'h1F0,
  parameter int PRI_CTL = 'h3F6,
  parameter int SEC_TF  = 'h170,
  parameter int SEC_CTL = 'h376
) (
  input  addr_mode_e        mode,
  input  logic              soft_rst,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              io_hit,
  output logic [3:0]        io_slot
);
  localparam int NWIN = 2;
  localparam logic [ADDR_W-1:0] TF_BASE  [NWIN] = '{ADDR_W'(PRI_TF),  ADDR_W'(SEC_TF)};
  localparam logic [ADDR_W-1:0] CTL_BASE [NWIN] = '{ADDR_W'(PRI_CTL), ADDR_W'(SEC_CTL)};

  logic [NWIN-1:0] tf_match, ctl_match;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign tf_match[g]  = (addr[ADDR_W-1:3] == TF_BASE[g][ADDR_W-1:3]);
    assign ctl_match[g] = (addr[ADDR_W-1:1] == CTL_BASE[g][ADDR_W-1:1]);
  end

  logic strobe;
  logic win;
  assign strobe = io_rd || io_wr;
  assign win    = (mode == MODE_SEC);

  always_comb begin
    io_hit  = 1'b0;
    io_slot = 4'd0;
    if (strobe && !soft_rst) begin
      case (mode)
        MODE_ANY16: begin
          io_hit  = 1'b1;
          io_slot = addr[3:0];
        end
        MODE_PRI, MODE_SEC: begin
          if (tf_match[win]) begin
            io_hit  = 1'b1;
            io_slot = {1'b0, addr[2:0]};
          end else if (ctl_match[win]) begin
            io_hit  = 1'b1;
            io_slot = {3'b111, addr[0]};
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_NO_HIT_UNCONF: assert (!(io_hit && (mode == MODE_MEM || soft_rst))) else $error("AST_NO_HIT_UNCONF"); // R9
    AST_HIT_NEEDS_STROBE: assert (!io_hit || io_rd || io_wr) else $error("AST_HIT_NEEDS_STROBE"); // R6
  end
endmodule

// File: rtl/pcc_irq_shape.sv
`timescale 1ns/1ps
module pcc_irq_shape #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic lvl_mode,
  output logic host_irq_n,
  output logic int_stat
);
  localparam int CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_W);

  logic             req_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = irq_req && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= irq_req;
      if (rise)              cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign host_irq_n = lvl_mode ? !req_q : (cnt_q == '0);
  assign int_stat   = req_q;

  AST_LEVEL_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && $past(rst_n)) |-> (host_irq_n == !$past(irq_req))) else $error("AST_LEVEL_TRACKS_REQ"); // R10
  AST_PULSE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(1)) |=> (cnt_q != '0)) else $error("AST_PULSE_NOT_CUT"); // R11
endmodule

// File: rtl/pcc_cfg_unit.sv
`timescale 1ns/1ps
module pcc_cfg_unit
  import pcc_cfg_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PULSE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              attr_we,
  input  logic              attr_re,
  output logic [7:0]        host_rdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              io_hit,
  output logic [3:0]        io_slot,
  output logic [1:0]        cfg_mode,
  output logic              core_rst,
  input  logic              irq_req,
  output logic              host_irq_n
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'('h202);

  logic       soft_rst, lvl_irq, int_stat;
  logic [5:0] cfg_index;
  addr_mode_e mode;

  pcc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .wdata(host_wdata),
    .attr_we(attr_we), .attr_re(attr_re), .int_stat(int_stat),
    .rdata(host_rdata), .soft_rst(soft_rst), .lvl_irq(lvl_irq), .cfg_index(cfg_index)
  );

  assign mode     = idx_to_mode(cfg_index);
  assign cfg_mode = mode;
  assign core_rst = soft_rst;

  pcc_io_decode #(.ADDR_W(ADDR_W)) u_dec (
    .mode(mode), .soft_rst(soft_rst), .io_rd(io_rd), .io_wr(io_wr),
    .addr(host_addr), .io_hit(io_hit), .io_slot(io_slot)
  );

  pcc_irq_shape #(.PULSE_W(PULSE_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .lvl_mode(lvl_irq),
    .host_irq_n(host_irq_n), .int_stat(int_stat)
  );

  AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_re && host_addr == STS_A) |-> ((host_rdata & 8'h99) == 8'h00)) else $error("AST_STS_RSVD_ZERO"); // R4
endmodule

// File: tb/pcc_cfg_unit_bench.sv
`timescale 1ns/1ps
module pcc_cfg_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        attr_we = 1'b0, attr_re = 1'b0, io_rd = 1'b0, io_wr = 1'b0, irq_req = 1'b0;
  logic [7:0]  host_rdata;
  logic        io_hit, core_rst, host_irq_n;
  logic [3:0]  io_slot;
  logic [1:0]  cfg_mode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcc_cfg_unit u_pcc_cfg_unit (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .attr_we(attr_we), .attr_re(attr_re), .host_rdata(host_rdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_hit(io_hit), .io_slot(io_slot),
    .cfg_mode(cfg_mode), .core_rst(core_rst), .irq_req(irq_req), .host_irq_n(host_irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic attr_write(input int a, input logic [7:0] v);
    @(negedge clk);
    host_addr = 11'(a); host_wdata = v; attr_we = 1'b1;
    @(negedge clk);
    attr_we = 1'b0;
  endtask

  task automatic attr_read(input int a, output logic [7:0] v);
    @(negedge clk);
    host_addr = 11'(a); attr_re = 1'b1;
    #1 v = host_rdata;
    attr_re = 1'b0;
  endtask

  task automatic io_access(input int a, input bit wr, output bit hit, output logic [3:0] slot);
    @(negedge clk);
    host_addr = 11'(a); io_rd = !wr; io_wr = wr;
    #1 hit = io_hit; slot = io_slot;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  function automatic int exp_mode(input logic [5:0] idx);
    return (idx >= 6'd1 && idx <= 6'd3) ? int'(idx) : 0;
  endfunction

  function automatic int exp_decode(input int m, input int a);
    int tf, ctl;
    if (m == 1) return 16 | (a & 15);
    if (m == 2 || m == 3) begin
      tf  = (m == 2) ? 'h1F0 : 'h170;
      ctl = (m == 2) ? 'h3F6 : 'h376;
      if (a >= tf && a <= tf + 7)   return 16 | (a - tf);
      if (a == ctl || a == ctl + 1) return 16 | (14 + a - ctl);
    end
    return 0;
  endfunction

  function automatic int pick_addr();
    case ($urandom_range(0, 4))
      0: return 'h1F0 + $urandom_range(0, 7);
      1: return 'h3F6 + $urandom_range(0, 1);
      2: return 'h170 + $urandom_range(0, 7);
      3: return 'h376 + $urandom_range(0, 1);
      default: return $urandom_range(0, 1023);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    bit hit;
    logic [3:0] slot;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    attr_read('h200, rv); chk(rv == 8'h00, "R1 opt reg", rv, 0);
    attr_read('h202, rv); chk(rv == 8'h00, "R1 sts reg", rv, 0);
    chk(host_irq_n == 1'b1 && core_rst == 1'b0 && cfg_mode == 2'd0, "R1 outputs",
        {host_irq_n, core_rst, cfg_mode}, 4'b1000);

    // R12 read gating
    attr_write('h200, 8'h42);
    @(negedge clk); host_addr = 11'h200; attr_re = 1'b0;
    #1 chk(host_rdata == 8'h00, "R12 no strobe", host_rdata, 0);
    attr_read('h204, rv); chk(rv == 8'h00, "R12 other addr", rv, 0);
    attr_read('h100, rv); chk(rv == 8'h00, "R12 other addr low", rv, 0);

    // R4 status register write mask and Int
    attr_write('h202, 8'hFF);
    attr_read('h202, rv); chk(rv == 8'h64, "R4 sts mask", rv, 'h64);
    attr_write('h202, 8'h9B);
    attr_read('h202, rv); chk(rv == 8'h00, "R4 sts readonly", rv, 0);
    attr_write('h202, 8'h20);

    // R10 level interrupt
    attr_write('h200, 8'h40);
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); chk(host_irq_n == 1'b0, "R10 level assert", host_irq_n, 0);
    repeat (6) @(negedge clk);
    chk(host_irq_n == 1'b0, "R10 level held", host_irq_n, 0);
    attr_read('h202, rv); chk(rv == 8'h22, "R4 int bit level", rv, 'h22);
    @(negedge clk); irq_req = 1'b0;
    @(negedge clk); chk(host_irq_n == 1'b1, "R10 level release", host_irq_n, 1);

    // R11 pulse interrupt
    attr_write('h200, 8'h00);
    @(negedge clk); irq_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk(host_irq_n == 1'b0, "R11 pulse low", host_irq_n, 0);
    end
    @(negedge clk); chk(host_irq_n == 1'b1, "R11 pulse end", host_irq_n, 1);
    repeat (5) @(negedge clk);
    chk(host_irq_n == 1'b1, "R11 no extend", host_irq_n, 1);
    attr_read('h202, rv); chk(rv == 8'h22, "R4 int bit pulse", rv, 'h22);
    @(negedge clk); irq_req = 1'b0;

    // R3 soft reset
    attr_write('h200, 8'h43);
    attr_write('h202, 8'h64);
    attr_write('h200, 8'h80);
    chk(core_rst == 1'b1, "R3 core_rst on", core_rst, 1);
    attr_read('h200, rv); chk(rv == 8'h80, "R3 fields cleared", rv, 'h80);
    attr_read('h202, rv); chk(rv == 8'h00, "R3 sts cleared", rv, 0);
    attr_write('h202, 8'h64);
    attr_read('h202, rv); chk(rv == 8'h00, "R3 sts write masked", rv, 0);
    attr_write('h200, 8'h83);
    attr_read('h200, rv); chk(rv == 8'h80, "R3 opt write masked", rv, 'h80);
    io_access('h1F0, 0, hit, slot); chk(!hit, "R9 srst no hit", hit, 0);
    attr_write('h200, 8'h00);
    chk(core_rst == 1'b0, "R3 core_rst off", core_rst, 0);
    attr_read('h200, rv); chk(rv == 8'h00, "R3 unconfigured", rv, 0);

    // R6 no strobe no hit
    attr_write('h200, 8'h01);
    @(negedge clk); host_addr = 11'h1F3;
    #1 chk(!io_hit, "R6 no strobe", io_hit, 0);

    // Random configurations and I/O decode
    for (int it = 0; it < 150; it++) begin
      logic [7:0] v;
      int m, e;
      v = {1'b0, 1'($urandom_range(0, 1)), 6'($urandom_range(0, 3))};
      if ($urandom_range(0, 5) == 0) v[5:0] = 6'($urandom_range(0, 63));
      attr_write('h200, v);
      attr_read('h200, rv); chk(rv == v, "R2 readback", rv, v);
      m = exp_mode(v[5:0]);
      chk(int'(cfg_mode) == m, "R5 mode", cfg_mode, m);
      for (int j = 0; j < 8; j++) begin
        int a;
        a = pick_addr();
        io_access(a, 1'($urandom_range(0, 1)), hit, slot);
        e = exp_decode(m, a);
        chk({27'd0, hit, slot} == ((e[4]) ? e : 0) || (!hit && e == 0),
            (m == 1) ? "R6 decode" : (m == 2) ? "R7 decode" : (m == 3) ? "R8 decode" : "R9 decode",
            {hit, slot}, e);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule